// File: doc/BRIEF.md
# Dual Auto-Reload PWM Timer with Forced Overflow

This block contains two independent up-counters, 12 bits wide by default. Each counter has its own reload value, its own pending duty value and its own active compare value, and each drives its own PWM output. A counter advances on every cycle in which the shared count enable is high. When a counter reaches its all-ones value, the next enabled cycle wraps it back to its reload value. That wrap is the overflow event. It emits a one-cycle pulse, sets a sticky flag and copies the pending duty value into the active compare register.

Software often needs a new duty value to apply without waiting out the remainder of a long period. To do this it sets the channel's force bit. On the next enabled cycle the counter jumps straight to all-ones. On the enabled cycle after that it overflows like any natural overflow, and hardware then clears the force bit. A small word-wide register port gives access to every channel setting. The address is formed as {channel, offset}, with offset 0 for reload, 1 for pending duty, 2 for control/status and 3 for the live count.

Top module: `dual_reload_timer`

## Requirements
- R1: After reset every counter, reload value, pending duty, active compare, force bit, flag and pulse is zero, every register read returns 0 and both PWM outputs are low.
- R2: On an enabled cycle a counter below all-ones (FFFh) with its force bit clear increments by one, and a counter at FFFh loads its channel's reload value (offset 0) instead.
- R3: Writing 1 to bit 0 of offset 2 sets that channel's force bit (read back at bit 0 of offset 2). On the next enabled cycle that counter becomes FFFh. The other channel is not affected.
- R4: Hardware clears the force bit on the overflow. A force write that lands in the same cycle as a natural overflow produces only that one overflow and leaves the bit clear.
- R5: Each overflow raises the channel's pulse output for exactly one cycle, starting in the cycle after the counter was at FFFh. It also sets the flag (read at bit 1 of offset 2, and on the flag output). Writing 1 to bit 1 of offset 2 clears the flag, and an overflow in the same cycle wins over the clear.
- R6: A write to offset 1 changes only the pending duty value, which reads back at offset 1. The active compare register takes the pending value at an overflow, whether natural or forced, and at no other time.
- R7: A PWM output is high exactly when reload <= count < active compare. It is therefore constantly low when the active compare is at or below the reload value.
- R8: While the enable is low, counters hold their value and a pending force bit stays set without moving the counter.
- R9: Reads return reload at offset 0, pending duty at offset 1, {flag, force} in bits 1:0 at offset 2 and the count at offset 3, with all upper bits zero. Writes to offset 3 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_en | input | 1 | Count enable shared by both channels |
| wr_en | input | 1 | Register write strobe |
| addr | input | CH_W+2 (3) | Register address {channel, offset} |
| wdata | input | DATA_W (16) | Write data |
| rdata | output | DATA_W (16) | Combinational read data for addr |
| pwm_o | output | N_CH (2) | PWM output per channel |
| ovf_pulse_o | output | N_CH (2) | One-cycle overflow pulse per channel |
| ovf_flag_o | output | N_CH (2) | Sticky overflow flag per channel |

## Verification
The bench builds the block with its defaults: two channels, a 12-bit count and a 16-bit data word. With these values a natural wrap takes at most 4096 enabled cycles, so a full period, the wrap from FFFh and a force write that coincides with a natural overflow all fit in a short run. Choosing reload values of E00h and 100h keeps the channels' periods different, so the test can show that a force on one channel leaves the other untouched. It also lets one channel hold a compare value below its reload, which must keep its PWM output low.

// File: rtl/drt_pkg.sv
package drt_pkg;

   typedef enum logic [1:0] {
      OFF_RELOAD = 2'd0,
      OFF_DUTY   = 2'd1,
      OFF_CTRL   = 2'd2,
      OFF_COUNT  = 2'd3
   } drt_off_e;

   localparam int CTRL_FORCE_BIT = 0;
   localparam int CTRL_FLAG_BIT  = 1;

endpackage

// File: rtl/drt_pwm_cmp.sv
module drt_pwm_cmp #(
   parameter int CNT_W = 12
) (
   input  logic [CNT_W-1:0] cnt,
   input  logic [CNT_W-1:0] reload,
   input  logic [CNT_W-1:0] duty,
   output logic             pwm
);

   logic window_ok;
   logic in_high;

   // a window that does not open above the reload value can never be high
   assign window_ok = duty > reload;
   assign in_high   = (cnt >= reload) && (cnt < duty);
   assign pwm       = window_ok && in_high;

endmodule

// File: rtl/drt_channel.sv
module drt_channel #(
   parameter int CNT_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             wr_reload,
   input  logic             wr_duty,
   input  logic             set_force,
   input  logic             clr_flag,
   input  logic [CNT_W-1:0] wval,
   output logic [CNT_W-1:0] cnt_o,
   output logic [CNT_W-1:0] reload_o,
   output logic [CNT_W-1:0] dsh_o,
   output logic [CNT_W-1:0] dact_o,
   output logic             force_o,
   output logic             flag_o,
   output logic             pulse_o,
   output logic             pwm_o
);

   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
   localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

   logic [CNT_W-1:0] cnt_q, reload_q, dsh_q, dact_q;
   logic             force_q, flag_q, pulse_q;
   logic             wrap;

   assign wrap = en && (cnt_q == CNT_MAX);

   // counter: wrap beats force, force beats increment
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (wrap) begin
         cnt_q <= reload_q;
      end else if (en && force_q) begin
         cnt_q <= CNT_MAX;
      end else if (en) begin
         cnt_q <= cnt_q + CNT_ONE;
      end
   end

   // force bit: hardware clear at overflow outranks a software set
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         force_q <= 1'b0;
      end else if (wrap) begin
         force_q <= 1'b0;
      end else if (set_force) begin
         force_q <= 1'b1;
      end
   end

   // overflow pulse and sticky flag
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pulse_q <= 1'b0;
         flag_q  <= 1'b0;
      end else begin
         pulse_q <= wrap;
         if (wrap) begin
            flag_q <= 1'b1;
         end else if (clr_flag) begin
            flag_q <= 1'b0;
         end
      end
   end

   // reload, pending duty, and transfer of duty at overflow
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         reload_q <= '0;
         dsh_q    <= '0;
         dact_q   <= '0;
      end else begin
         if (wr_reload) begin
            reload_q <= wval;
         end
         if (wr_duty) begin
            dsh_q <= wval;
         end
         if (wrap) begin
            dact_q <= dsh_q;
         end
      end
   end

   drt_pwm_cmp #(.CNT_W(CNT_W)) u_cmp (
      .cnt    (cnt_q),
      .reload (reload_q),
      .duty   (dact_q),
      .pwm    (pwm_o)
   );

   assign cnt_o    = cnt_q;
   assign reload_o = reload_q;
   assign dsh_o    = dsh_q;
   assign dact_o   = dact_q;
   assign force_o  = force_q;
   assign flag_o   = flag_q;
   assign pulse_o  = pulse_q;

endmodule

// File: rtl/dual_reload_timer.sv
module dual_reload_timer #(
   parameter  int N_CH   = 2,
   parameter  int CNT_W  = 12,
   parameter  int DATA_W = 16,
   localparam int CH_W   = (N_CH > 1) ? $clog2(N_CH) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cnt_en,
   input  logic              wr_en,
   input  logic [CH_W+1:0]   addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic [N_CH-1:0]   pwm_o,
   output logic [N_CH-1:0]   ovf_pulse_o,
   output logic [N_CH-1:0]   ovf_flag_o
);
   import drt_pkg::*;

   if (N_CH < 1) begin : g_bad_nch
      $error("dual_reload_timer: N_CH must be at least 1");
   end
   if (CNT_W < 2) begin : g_bad_cntw
      $error("dual_reload_timer: CNT_W must be at least 2");
   end
   if (DATA_W <= CNT_W) begin : g_bad_dataw
      $error("dual_reload_timer: DATA_W must exceed CNT_W");
   end

   logic [CH_W-1:0] sel_ch;
   drt_off_e        sel_off;

   logic [N_CH-1:0][CNT_W-1:0] ch_cnt, ch_reload, ch_dsh, ch_dact;
   logic [N_CH-1:0]            ch_force, ch_flag;
   logic                       unused_wdata;

   assign sel_ch       = addr[CH_W+1:2];
   assign sel_off      = drt_off_e'(addr[1:0]);
   assign unused_wdata = ^wdata[DATA_W-1:CNT_W];

   for (genvar c = 0; c < N_CH; c++) begin : g_ch
      logic hit;
      assign hit = wr_en && (int'(sel_ch) == c);

      drt_channel #(.CNT_W(CNT_W)) u_ch (
         .clk       (clk),
         .rst_n     (rst_n),
         .en        (cnt_en),
         .wr_reload (hit && (sel_off == OFF_RELOAD)),
         .wr_duty   (hit && (sel_off == OFF_DUTY)),
         .set_force (hit && (sel_off == OFF_CTRL) && wdata[CTRL_FORCE_BIT]),
         .clr_flag  (hit && (sel_off == OFF_CTRL) && wdata[CTRL_FLAG_BIT]),
         .wval      (wdata[CNT_W-1:0]),
         .cnt_o     (ch_cnt[c]),
         .reload_o  (ch_reload[c]),
         .dsh_o     (ch_dsh[c]),
         .dact_o    (ch_dact[c]),
         .force_o   (ch_force[c]),
         .flag_o    (ch_flag[c]),
         .pulse_o   (ovf_pulse_o[c]),
         .pwm_o     (pwm_o[c])
      );
   end

   assign ovf_flag_o = ch_flag;

   always_comb begin
      rdata = '0;
      for (int c = 0; c < N_CH; c++) begin
         if (int'(sel_ch) == c) begin
            case (sel_off)
               OFF_RELOAD: rdata[CNT_W-1:0] = ch_reload[c];
               OFF_DUTY:   rdata[CNT_W-1:0] = ch_dsh[c];
               OFF_CTRL: begin
                  rdata[CTRL_FORCE_BIT] = ch_force[c];
                  rdata[CTRL_FLAG_BIT]  = ch_flag[c];
               end
               default:    rdata[CNT_W-1:0] = ch_cnt[c];
            endcase
         end
      end
   end

endmodule

// File: rtl/drt_checker.sv
module drt_checker #(
   parameter int N_CH  = 2,
   parameter int CNT_W = 12
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic                       en,
   input logic [N_CH-1:0][CNT_W-1:0] cnt,
   input logic [N_CH-1:0][CNT_W-1:0] reload,
   input logic [N_CH-1:0][CNT_W-1:0] dsh,
   input logic [N_CH-1:0][CNT_W-1:0] dact,
   input logic [N_CH-1:0]            frc,
   input logic [N_CH-1:0]            flag,
   input logic [N_CH-1:0]            pulse,
   input logic [N_CH-1:0]            pwm
);

   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
   localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

   for (genvar i = 0; i < N_CH; i++) begin : g_chk
      // R2
      a_r2_wrap: assert property (@(posedge clk) disable iff (!rst_n)
         (en && cnt[i] == CNT_MAX) |=> (cnt[i] == $past(reload[i])));
      // R2
      a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
         (en && !frc[i] && cnt[i] != CNT_MAX) |=> (cnt[i] == $past(cnt[i]) + CNT_ONE));
      // R3
      a_r3_force_jump: assert property (@(posedge clk) disable iff (!rst_n)
         (en && frc[i] && cnt[i] != CNT_MAX) |=> (cnt[i] == CNT_MAX));
      // R4
      a_r4_force_cleared: assert property (@(posedge clk) disable iff (!rst_n)
         (en && cnt[i] == CNT_MAX) |=> !frc[i]);
      // R5
      a_r5_pulse_on: assert property (@(posedge clk) disable iff (!rst_n)
         (en && cnt[i] == CNT_MAX) |=> pulse[i]);
      // R5
      a_r5_pulse_off: assert property (@(posedge clk) disable iff (!rst_n)
         !(en && cnt[i] == CNT_MAX) |=> !pulse[i]);
      // R5
      a_r5_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
         pulse[i] |-> flag[i]);
      // R6
      a_r6_transfer: assert property (@(posedge clk) disable iff (!rst_n)
         (en && cnt[i] == CNT_MAX) |=> (dact[i] == $past(dsh[i])));
      // R6
      a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
         !(en && cnt[i] == CNT_MAX) |=> $stable(dact[i]));
      // R7
      a_r7_low_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
         (dact[i] <= reload[i]) |-> !pwm[i]);
      // R8
      a_r8_hold_disabled: assert property (@(posedge clk) disable iff (!rst_n)
         !en |=> $stable(cnt[i]));
   end

endmodule

bind dual_reload_timer drt_checker #(.N_CH(N_CH), .CNT_W(CNT_W)) u_drt_checker (
   .clk    (clk),
   .rst_n  (rst_n),
   .en     (cnt_en),
   .cnt    (ch_cnt),
   .reload (ch_reload),
   .dsh    (ch_dsh),
   .dact   (ch_dact),
   .frc    (ch_force),
   .flag   (ch_flag),
   .pulse  (ovf_pulse_o),
   .pwm    (pwm_o)
);

// File: tb/dual_reload_timer_bench.sv
module dual_reload_timer_bench;

   localparam int CLK_P   = 10;
   localparam int MAXV    = 4095;
   localparam int WD_LIM  = 100000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cnt_en = 1'b0;
   logic        wr_en = 1'b0;
   logic [2:0]  addr = '0;
   logic [15:0] wdata = '0;
   logic [15:0] rdata;
   logic [1:0]  pwm_o, ovf_pulse_o, ovf_flag_o;

   int errors = 0;
   int checks = 0;
   int cycles = 0;

   int m_cnt[2], m_rel[2], m_sh[2], m_act[2], m_frc[2], m_flg[2], m_pul[2];

   dual_reload_timer u_dual_reload_timer (
      .clk         (clk),
      .rst_n       (rst_n),
      .cnt_en      (cnt_en),
      .wr_en       (wr_en),
      .addr        (addr),
      .wdata       (wdata),
      .rdata       (rdata),
      .pwm_o       (pwm_o),
      .ovf_pulse_o (ovf_pulse_o),
      .ovf_flag_o  (ovf_flag_o)
   );

   always #(CLK_P/2) clk = ~clk;

   task automatic chk(input int act, input int exp, input string tag);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic int exp_read(input int a);
      int c, o;
      c = a / 4;
      o = a % 4;
      case (o)
         0: return m_rel[c];
         1: return m_sh[c];
         2: return m_flg[c] * 2 + m_frc[c];
         default: return m_cnt[c];
      endcase
   endfunction

   function automatic int exp_pwm(input int c);
      return (m_act[c] > m_rel[c] && m_cnt[c] >= m_rel[c] && m_cnt[c] < m_act[c]) ? 1 : 0;
   endfunction

   // behavioural reference, advanced on every clock
   always @(posedge clk) begin
      if (!rst_n) begin
         for (int c = 0; c < 2; c++) begin
            m_cnt[c] = 0; m_rel[c] = 0; m_sh[c] = 0; m_act[c] = 0;
            m_frc[c] = 0; m_flg[c] = 0; m_pul[c] = 0;
         end
      end else begin
         for (int c = 0; c < 2; c++) begin
            bit hit, wrap;
            int o;
            hit  = wr_en && (int'(addr[2]) == c);
            o    = int'(addr[1:0]);
            wrap = cnt_en && (m_cnt[c] == MAXV);
            m_pul[c] = wrap ? 1 : 0;
            if (wrap) begin
               m_cnt[c] = m_rel[c];
               m_act[c] = m_sh[c];
               m_frc[c] = 0;
               m_flg[c] = 1;
            end else begin
               if (cnt_en && m_frc[c] == 1) m_cnt[c] = MAXV;
               else if (cnt_en) m_cnt[c] = m_cnt[c] + 1;
               if (hit && o == 2 && wdata[0]) m_frc[c] = 1;
               if (hit && o == 2 && wdata[1]) m_flg[c] = 0;
            end
            if (hit && o == 0) m_rel[c] = int'(wdata[11:0]);
            if (hit && o == 1) m_sh[c] = int'(wdata[11:0]);
         end
      end
      #(CLK_P/4);
      if (rst_n) begin
         for (int c = 0; c < 2; c++) begin
            chk(int'(pwm_o[c]), exp_pwm(c), "R7 pwm vs model");
            chk(int'(ovf_pulse_o[c]), m_pul[c], "R5 pulse vs model");
            chk(int'(ovf_flag_o[c]), m_flg[c], "R5 flag vs model");
         end
         chk(int'(rdata), exp_read(int'(addr)), "R9 read vs model");
      end
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > WD_LIM) begin
         errors++;
         checks++;
         $display("FAIL R2 watchdog actual=%0d expected=%0d", cycles, WD_LIM);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   task automatic wr(input int a, input int d);
      @(negedge clk);
      wr_en = 1'b1;
      addr  = 3'(a);
      wdata = 16'(d);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd_chk(input int a, input int exp, input string tag);
      addr = 3'(a);
      #1;
      chk(int'(rdata), exp, tag);
   endtask

   task automatic wait_cnt(input int c, input int v);
      while (m_cnt[c] != v) begin
         @(posedge clk);
         #(CLK_P/4 + 1);
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: everything zero after reset
      for (int a = 0; a < 8; a++) rd_chk(a, 0, "R1 reset read");
      chk(int'(pwm_o), 0, "R1 pwm after reset");
      chk(int'(ovf_flag_o), 0, "R1 flag after reset");

      wr(0, 16'h0E00);
      wr(1, 16'h0E80);
      wr(4, 16'h0100);
      wr(5, 16'h0800);
      rd_chk(1, 16'h0E80, "R6 pending duty readback");
      repeat (5) @(negedge clk);
      rd_chk(3, 0, "R8 counter held while disabled");

      // R2: counting from zero
      addr = 3'd3;
      cnt_en = 1'b1;
      repeat (20) @(negedge clk);
      rd_chk(3, 20, "R2 increment count");
      chk(int'(pwm_o[0]), 0, "R6 active compare not yet loaded");

      // R3: forced jump on channel 0
      wr(2, 1);
      rd_chk(2, 1, "R3 force bit set");
      @(negedge clk);
      rd_chk(3, MAXV, "R3 jump to all-ones");
      rd_chk(7, m_cnt[1], "R3 channel 1 unaffected");
      @(negedge clk);
      rd_chk(3, 16'h0E00, "R2 restart at reload after forced overflow");
      chk(int'(ovf_pulse_o[0]), 1, "R5 pulse on forced overflow");
      @(negedge clk);
      chk(int'(ovf_pulse_o[0]), 0, "R5 pulse lasts one cycle");
      rd_chk(2, 2, "R4 force cleared, flag set");
      chk(int'(pwm_o[0]), 1, "R6 new duty active after forced overflow");

      // R5: flag clear
      wr(2, 2);
      rd_chk(2, 0, "R5 flag cleared by write one");

      // R4: force write coinciding with natural overflow
      wait_cnt(0, MAXV);
      @(negedge clk);
      wr_en = 1'b1; addr = 3'd2; wdata = 16'h0001;
      @(negedge clk);
      wr_en = 1'b0;
      rd_chk(2, 2, "R4 coincident force ignored");
      chk(int'(ovf_pulse_o[0]), 1, "R4 single overflow pulse");
      repeat (3) @(negedge clk);
      rd_chk(3, 16'h0E03, "R4 no second overflow");

      // R9: counter address is read-only
      wr(3, 16'h0123);
      rd_chk(3, m_cnt[0], "R9 count write ignored");
      rd_chk(3, m_cnt[0] & 16'h0FFF, "R9 upper bits zero");

      // R8: pending force waits while disabled
      cnt_en = 1'b0;
      wr(6, 1);
      repeat (3) @(negedge clk);
      rd_chk(7, m_cnt[1], "R8 counter held with force pending");
      rd_chk(6, 1, "R8 force still pending");
      cnt_en = 1'b1;
      @(negedge clk);
      rd_chk(7, MAXV, "R3 pending force applied once enabled");

      // R7: compare below reload gives constant low
      wr(5, 16'h0080);
      wr(6, 1);
      repeat (4) @(negedge clk);
      for (int k = 0; k < 300; k++) begin
         @(negedge clk);
         chk(int'(pwm_o[1]), 0, "R7 compare below reload stays low");
      end

      repeat (50) @(negedge clk);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule